// File: doc/BRIEF.md
# SPI Flash Command Engine

This block lets a host run one complete SPI flash command through a small byte-wide register window and collect the reply. The host first loads an 8-bit opcode and up to three argument bytes. It then writes one control byte. That single write starts the transaction and packs three fields: the serial clock rate, how many argument bytes follow the opcode, and how many reply bytes to collect.

While the engine runs, a busy flag in the status register reads as 1. During that time the engine holds chip select low. It shifts out the opcode and the argument bytes MSB first in SPI mode 0. If reply bytes are requested, it keeps clocking with MOSI at zero and stores each reply byte in a fixed register. A typical use is a device-ID read: load opcode 0x9F, write a control byte that asks for three reply bytes, poll busy until it clears, then read the three ID bytes.

The serial clock comes from a divider. A table built from a parameter maps each clock-select value to a half-period count.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sck is 0, and every register offset 0 to 7 reads 0x00.
- R2: Offset 1 holds the opcode and offsets 2, 3 and 4 hold argument bytes; each reads back the last value written. Offset 0 reads {busy, control[6:0]}. Bit 7 of a control write is not stored.
- R3: A write to offset 0 while idle starts a transfer. From the next clock cycle, bit 7 of offset 0 reads 1 and spi_cs_n is 0. Both return to idle together when the transfer ends.
- R4: Control bits 6:4 are the clock select, bits 3:2 the reply byte count and bits 1:0 the argument byte count. A transfer gives exactly 8*(1+args+replies) rising edges of spi_sck.
- R5: While spi_sck runs, each level of spi_sck lasts HALF_MAX >> sel system clock cycles, floored at 1. With the default HALF_MAX=128, select 5 gives 4 cycles and select 7 gives 1 cycle.
- R6: SPI mode 0. spi_sck is 0 whenever spi_cs_n is 1. spi_mosi changes only while spi_sck is 0, and bits go out MSB first.
- R7: Bytes go out in this order: the opcode, then offsets 2, 3 and 4 up to the argument count. During the reply bytes, spi_mosi is 0.
- R8: The first reply byte is stored at offset 5, the second at 6 and the third at 7. At the start of every transfer, offsets 5 to 7 are cleared to 0x00, so any byte that is not requested reads 0x00.
- R9: A write to any offset while busy reads 1 is ignored. It neither starts a transfer nor changes any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for reg_addr (combinational) |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the flash |
| spi_miso | input | 1 | Serial data from the flash |

## Verification
The bench uses the default HALF_MAX of 128. This makes the whole range of clock selects usable. Select 0 stretches each sck level to 128 cycles, which leaves a long busy window for the ignored-write checks. Select 7 runs sck at one cycle per level, which tests the divider at its tightest setting. A flash model inside the bench answers the ID opcode with a fixed three-byte ID. It answers an echo opcode by returning the inverse of each byte it just received, so argument order, zero-filled MOSI and reply placement can all be seen from the registers.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;
  localparam int ADDR_W  = 3;
  localparam int DATA_W  = 8;
  localparam int SEL_W   = 3;
  localparam int CNT_W   = 2;
  localparam int NUM_TX  = 3;
  localparam int NUM_RX  = 3;
  localparam int BYTE_W  = 3;  // wide enough for 1 + 3 + 3 bytes
  localparam int NUM_SEL = 1 << SEL_W;

  localparam logic [ADDR_W-1:0] OFS_CTL = 3'd0;
  localparam logic [ADDR_W-1:0] OFS_OP  = 3'd1;
  localparam int                TX_BASE = 2;
  localparam int                RX_BASE = 5;

  typedef struct packed {
    logic [SEL_W-1:0] clk_sel;  // bits 6:4
    logic [CNT_W-1:0] rd_cnt;   // bits 3:2
    logic [CNT_W-1:0] wr_cnt;   // bits 1:0
  } ctl_t;

  typedef enum logic [1:0] {
    SQ_IDLE  = 2'd0,
    SQ_SHIFT = 2'd1,
    SQ_HOLD  = 2'd2
  } seq_state_e;
endpackage

// File: rtl/spi_clk_div.sv
module spi_clk_div
  import spi_cmd_pkg::*;
#(
  parameter int HALF_MAX = 128
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [SEL_W-1:0] sel,
  output logic             tick
);
  localparam int CW = $clog2(HALF_MAX) + 1;

  logic [CW-1:0] half_tbl [NUM_SEL];
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] half_cur;

  // one half-period length per clock select, never below one cycle
  for (genvar g = 0; g < NUM_SEL; g++) begin : g_tbl
    localparam int HV = ((HALF_MAX >> g) < 1) ? 1 : (HALF_MAX >> g);
    assign half_tbl[g] = CW'(HV);
  end

  assign half_cur = half_tbl[sel];
  assign tick     = en && (cnt_q == half_cur - CW'(1));

  always_comb begin
    if (!en)       cnt_d = '0;
    else if (tick) cnt_d = '0;
    else           cnt_d = cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
  import spi_cmd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          reg_wr,
  input  logic [ADDR_W-1:0]             reg_addr,
  input  logic [DATA_W-1:0]             reg_wdata,
  output logic [DATA_W-1:0]             reg_rdata,
  input  logic                          busy,
  input  logic [NUM_RX-1:0]             rx_we,
  input  logic [DATA_W-1:0]             rx_byte,
  output logic                          start,
  output logic [DATA_W-1:0]             opcode,
  output logic [NUM_TX-1:0][DATA_W-1:0] tx_bytes,
  output ctl_t                          ctl
);
  logic                          wr_ok;
  ctl_t                          ctl_q, ctl_d;
  logic [DATA_W-1:0]             op_q, op_d;
  logic [NUM_TX-1:0][DATA_W-1:0] tx_q, tx_d;
  logic [NUM_RX-1:0][DATA_W-1:0] rx_q, rx_d;

  assign wr_ok = reg_wr && !busy;
  assign start = wr_ok && (reg_addr == OFS_CTL);

  always_comb begin
    ctl_d = ctl_q;
    op_d  = op_q;
    tx_d  = tx_q;
    rx_d  = rx_q;
    if (start) ctl_d = ctl_t'(reg_wdata[6:0]);
    if (wr_ok && reg_addr == OFS_OP) op_d = reg_wdata;
    for (int i = 0; i < NUM_TX; i++) begin
      if (wr_ok && reg_addr == ADDR_W'(TX_BASE + i)) tx_d[i] = reg_wdata;
    end
    for (int i = 0; i < NUM_RX; i++) begin
      if (start)         rx_d[i] = '0;
      else if (rx_we[i]) rx_d[i] = rx_byte;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      op_q  <= '0;
      tx_q  <= '0;
      rx_q  <= '0;
    end else begin
      ctl_q <= ctl_d;
      op_q  <= op_d;
      tx_q  <= tx_d;
      rx_q  <= rx_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == OFS_CTL) reg_rdata = {busy, ctl_q};
    if (reg_addr == OFS_OP)  reg_rdata = op_q;
    for (int i = 0; i < NUM_TX; i++) begin
      if (reg_addr == ADDR_W'(TX_BASE + i)) reg_rdata = tx_q[i];
    end
    for (int i = 0; i < NUM_RX; i++) begin
      if (reg_addr == ADDR_W'(RX_BASE + i)) reg_rdata = rx_q[i];
    end
  end

  assign opcode   = op_q;
  assign tx_bytes = tx_q;
  assign ctl      = ctl_q;
endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
  import spi_cmd_pkg::*;
(
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          start,
  input  ctl_t                          ctl,
  input  logic [DATA_W-1:0]             opcode,
  input  logic [NUM_TX-1:0][DATA_W-1:0] tx_bytes,
  input  logic                          tick,
  input  logic                          spi_miso,
  output logic                          busy,
  output logic                          spi_cs_n,
  output logic                          spi_sck,
  output logic                          spi_mosi,
  output logic [NUM_RX-1:0]             rx_we,
  output logic [DATA_W-1:0]             rx_byte
);
  seq_state_e        state_q, state_d;
  logic              sck_q, sck_d;
  logic              cs_n_q, cs_n_d;
  logic [DATA_W-1:0] tx_sr_q, tx_sr_d;
  logic [DATA_W-1:0] rx_sr_q, rx_sr_d;
  logic [2:0]        bit_q, bit_d;
  logic [BYTE_W-1:0] byte_q, byte_d;
  logic [BYTE_W-1:0] wr_n, last_byte, nxt_idx, rx_sel;
  logic [DATA_W-1:0] nxt_byte;
  logic              rx_fire;

  assign wr_n      = BYTE_W'(ctl.wr_cnt);
  assign last_byte = wr_n + BYTE_W'(ctl.rd_cnt);
  assign nxt_idx   = byte_q + BYTE_W'(1);
  assign rx_sel    = byte_q - wr_n - BYTE_W'(1);

  // next outgoing byte: argument bytes up to the count, zeros after
  always_comb begin
    nxt_byte = '0;
    for (int i = 0; i < NUM_TX; i++) begin
      if (nxt_idx == BYTE_W'(i + 1) && nxt_idx <= wr_n) nxt_byte = tx_bytes[i];
    end
  end

  always_comb begin
    state_d = state_q;
    sck_d   = sck_q;
    cs_n_d  = cs_n_q;
    tx_sr_d = tx_sr_q;
    rx_sr_d = rx_sr_q;
    bit_d   = bit_q;
    byte_d  = byte_q;
    rx_fire = 1'b0;
    case (state_q)
      SQ_IDLE: begin
        if (start) begin
          state_d = SQ_SHIFT;
          cs_n_d  = 1'b0;
          sck_d   = 1'b0;
          bit_d   = '0;
          byte_d  = '0;
          tx_sr_d = opcode;
        end
      end
      SQ_SHIFT: begin
        if (tick) begin
          if (!sck_q) begin
            sck_d   = 1'b1;
            rx_sr_d = {rx_sr_q[DATA_W-2:0], spi_miso};
          end else begin
            sck_d = 1'b0;
            if (bit_q == 3'd7) begin
              rx_fire = (byte_q > wr_n);
              if (byte_q == last_byte) begin
                state_d = SQ_HOLD;
              end else begin
                byte_d  = nxt_idx;
                bit_d   = '0;
                tx_sr_d = nxt_byte;
              end
            end else begin
              bit_d   = bit_q + 3'd1;
              tx_sr_d = {tx_sr_q[DATA_W-2:0], 1'b0};
            end
          end
        end
      end
      SQ_HOLD: begin
        if (tick) begin
          cs_n_d  = 1'b1;
          state_d = SQ_IDLE;
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      sck_q   <= 1'b0;
      cs_n_q  <= 1'b1;
      tx_sr_q <= '0;
      rx_sr_q <= '0;
      bit_q   <= '0;
      byte_q  <= '0;
    end else begin
      state_q <= state_d;
      sck_q   <= sck_d;
      cs_n_q  <= cs_n_d;
      tx_sr_q <= tx_sr_d;
      rx_sr_q <= rx_sr_d;
      bit_q   <= bit_d;
      byte_q  <= byte_d;
    end
  end

  for (genvar g = 0; g < NUM_RX; g++) begin : g_rxwe
    assign rx_we[g] = rx_fire && (rx_sel == BYTE_W'(g));
  end

  assign busy     = (state_q != SQ_IDLE);
  assign spi_cs_n = cs_n_q;
  assign spi_sck  = sck_q;
  assign spi_mosi = !cs_n_q && tx_sr_q[DATA_W-1];
  assign rx_byte  = rx_sr_q;
endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
  import spi_cmd_pkg::*;
#(
  parameter int HALF_MAX = 128
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_cs_n,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso
);
  logic [1:0]                    rst_sync_q;
  logic                          rst_int_n;
  logic                          busy;
  logic                          start;
  logic                          tick;
  ctl_t                          ctl_cfg;
  logic [DATA_W-1:0]             opcode;
  logic [NUM_TX-1:0][DATA_W-1:0] tx_bytes;
  logic [NUM_RX-1:0]             rx_we;
  logic [DATA_W-1:0]             rx_byte;

  // reset asserts at once and is released two clock edges later
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  spi_cmd_regs u_regs (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .busy     (busy),
    .rx_we    (rx_we),
    .rx_byte  (rx_byte),
    .start    (start),
    .opcode   (opcode),
    .tx_bytes (tx_bytes),
    .ctl      (ctl_cfg)
  );

  spi_clk_div #(.HALF_MAX(HALF_MAX)) u_div (
    .clk  (clk),
    .rst_n(rst_int_n),
    .en   (busy),
    .sel  (ctl_cfg.clk_sel),
    .tick (tick)
  );

  spi_cmd_seq u_seq (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .start   (start),
    .ctl     (ctl_cfg),
    .opcode  (opcode),
    .tx_bytes(tx_bytes),
    .tick    (tick),
    .spi_miso(spi_miso),
    .busy    (busy),
    .spi_cs_n(spi_cs_n),
    .spi_sck (spi_sck),
    .spi_mosi(spi_mosi),
    .rx_we   (rx_we),
    .rx_byte (rx_byte)
  );
endmodule

// File: rtl/spi_cmd_engine_chk.sv
module spi_cmd_engine_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_wr,
  input logic [2:0] reg_addr,
  input logic       busy,
  input logic [6:0] ctl_bits,
  input logic       spi_cs_n,
  input logic       spi_sck,
  input logic       spi_mosi
);
  assert_cs_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> spi_cs_n);

  assert_busy_from_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_wr && reg_addr == 3'd0));

  assert_sck_low_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    spi_cs_n |-> !spi_sck);

  assert_mosi_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_ctl_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && reg_wr && reg_addr == 3'd0) |=> $stable(ctl_bits));
endmodule

bind spi_cmd_engine spi_cmd_engine_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .reg_wr  (reg_wr),
  .reg_addr(reg_addr),
  .busy    (busy),
  .ctl_bits(ctl_cfg),
  .spi_cs_n(spi_cs_n),
  .spi_sck (spi_sck),
  .spi_mosi(spi_mosi)
);

// File: tb/spi_cmd_engine_bench.sv
`timescale 1ns/1ps
module spi_cmd_engine_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       reg_wr;
  logic [2:0] reg_addr;
  logic [7:0] reg_wdata;
  logic [7:0] reg_rdata;
  logic       spi_cs_n, spi_sck, spi_mosi;
  logic       spi_miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;

  always #10 clk = ~clk;  // 50 MHz

  spi_cmd_engine u_spi_cmd_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_cs_n(spi_cs_n),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // ---------------- behavioural flash ----------------
  localparam logic [7:0] ID0 = 8'h5A, ID1 = 8'hC3, ID2 = 8'h17;
  logic [7:0] m_rx [8];
  logic [7:0] m_sr, m_tx;
  int         m_bit, m_byte, m_rises;
  logic       prev_cs = 1'b1, prev_sck = 1'b0;

  function automatic logic [7:0] m_resp(int idx);
    if (m_rx[0] == 8'h9F) begin
      if (idx == 1) return ID0;
      if (idx == 2) return ID1;
      if (idx == 3) return ID2;
      return 8'h00;
    end
    if (m_rx[0] == 8'h3C) return ~m_rx[idx-1];
    return 8'h00;
  endfunction

  always @(spi_cs_n or spi_sck) begin
    if (prev_cs === 1'b1 && spi_cs_n === 1'b0) begin
      m_bit = 0; m_byte = 0; m_rises = 0; m_tx = 8'h00; spi_miso = 1'b0;
      for (int i = 0; i < 8; i++) m_rx[i] = 8'h00;
    end else if (spi_cs_n === 1'b0 && prev_sck === 1'b0 && spi_sck === 1'b1) begin
      m_sr = {m_sr[6:0], spi_mosi};
      m_bit++; m_rises++;
      if (m_bit == 8) begin
        m_rx[m_byte] = m_sr; m_byte++; m_bit = 0;
      end
    end else if (spi_cs_n === 1'b0 && prev_sck === 1'b1 && spi_sck === 1'b0) begin
      if (m_bit == 0) m_tx = m_resp(m_byte);
      spi_miso = m_tx[7-m_bit];
    end
    prev_cs  = spi_cs_n;
    prev_sck = spi_sck;
  end

  // ---------------- scoreboard ----------------
  typedef struct { logic [7:0] exp; string req; } exp_t;
  exp_t sb_q[$];
  logic mon_req = 1'b0;

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    #5;
    if (mon_req) begin
      exp_t it;
      it = sb_q.pop_front();
      check(it.req, 32'(reg_rdata), 32'(it.exp));
    end
  end

  task automatic expect_rd(logic [2:0] a, logic [7:0] e, string req);
    exp_t it;
    @(negedge clk);
    reg_addr = a;
    it.exp = e; it.req = req;
    sb_q.push_back(it);
    mon_req = 1'b1;
    @(negedge clk);
    mon_req = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 60000; k++) begin
      @(negedge clk);
      reg_addr = 3'd0;
      #1;
      if (reg_rdata[7] === 1'b0) break;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  realtime t0, t1;

  initial begin
    rst_n = 1'b0; reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    check("R1 cs_n", 32'(spi_cs_n), 32'd1);
    check("R1 sck", 32'(spi_sck), 32'd0);
    for (int a = 0; a < 8; a++) expect_rd(3'(a), 8'h00, "R1 reg");

    // R2: register readback
    wr(3'd1, 8'h9F); wr(3'd2, 8'h11); wr(3'd3, 8'h22); wr(3'd4, 8'h33);
    expect_rd(3'd1, 8'h9F, "R2 opcode");
    expect_rd(3'd2, 8'h11, "R2 arg0");
    expect_rd(3'd4, 8'h33, "R2 arg2");

    // ID read: sel 5, 3 replies, 0 args; bit 7 of control not stored
    wr(3'd0, 8'hDC);
    check("R3 cs_n low", 32'(spi_cs_n), 32'd0);
    expect_rd(3'd0, 8'hDC, "R3 busy");
    @(posedge spi_sck); t0 = $realtime;
    @(negedge spi_sck); t1 = $realtime;
    check("R5 half sel5", 32'(int'((t1 - t0) / 20.0)), 32'd4);
    wait_idle();
    check("R3 cs_n released", 32'(spi_cs_n), 32'd1);
    check("R4 edges 1+0+3", 32'(m_rises), 32'd32);
    check("R6 opcode msb first", 32'(m_rx[0]), 32'h9F);
    expect_rd(3'd0, 8'h5C, "R2 status idle");
    expect_rd(3'd5, ID0, "R8 first");
    expect_rd(3'd6, ID1, "R8 second");
    expect_rd(3'd7, ID2, "R8 third");

    // echo: sel 7, 3 args, 2 replies
    wr(3'd1, 8'h3C); wr(3'd2, 8'hA1); wr(3'd3, 8'hB2); wr(3'd4, 8'hC3);
    wr(3'd0, 8'h7B);
    @(posedge spi_sck); t0 = $realtime;
    @(negedge spi_sck); t1 = $realtime;
    check("R5 half sel7", 32'(int'((t1 - t0) / 20.0)), 32'd1);
    wait_idle();
    check("R4 edges 1+3+2", 32'(m_rises), 32'd48);
    check("R7 arg0", 32'(m_rx[1]), 32'hA1);
    check("R7 arg1", 32'(m_rx[2]), 32'hB2);
    check("R7 arg2", 32'(m_rx[3]), 32'hC3);
    check("R7 mosi zero", 32'(m_rx[4]), 32'h00);
    expect_rd(3'd5, 8'h3C, "R8 echo first");
    expect_rd(3'd6, 8'hFF, "R8 echo second");
    expect_rd(3'd7, 8'h00, "R8 cleared");

    // one arg, one reply, sel 6
    wr(3'd0, 8'h65);
    wait_idle();
    check("R4 edges 1+1+1", 32'(m_rises), 32'd24);
    expect_rd(3'd5, 8'h5E, "R8 single");
    expect_rd(3'd6, 8'h00, "R8 cleared 6");

    // R9: writes while busy are ignored (slow sel 0)
    wr(3'd1, 8'h9F);
    wr(3'd0, 8'h0C);
    wr(3'd0, 8'h7F);
    wr(3'd1, 8'h00);
    wr(3'd2, 8'hEE);
    expect_rd(3'd0, 8'h8C, "R9 ctl kept");
    wait_idle();
    check("R9 no restart", 32'(m_rises), 32'd32);
    expect_rd(3'd1, 8'h9F, "R9 opcode kept");
    expect_rd(3'd2, 8'hA1, "R9 arg kept");
    expect_rd(3'd5, ID0, "R9 reply intact");
    expect_rd(3'd7, ID2, "R9 reply intact 7");

    repeat (4) @(negedge clk);
    check("R9 scoreboard drained", 32'(sb_q.size()), 32'd0);
    summary();
  end
endmodule